// File: doc/BRIEF.md
# Phase-Aligned Divided Clock Bank

The bank produces a set of divided clock outputs from a small group of source clocks. The sources are represented as tick strobes in the bank's own clock domain. Each output picks one source through a selector and divides its ticks by a per-output code. Every source carries one shared enable and one shared clear. Any output that uses a given source responds to that pair unless its own mask bit tells it to ignore the control.

Each source has one synchronizer pair. Release from clear passes through it, and so do both edges of enable. Every unmasked output on that source therefore sees the change on the same source tick, and those outputs rise together after release. An output with its clear mask or enable mask set keeps counting with the phase and divide it already had. Masks are the intended way to keep an output always running; the shared controls are never tied off. Clear assertion does not wait for a tick: it pulls the output low on the next bank clock edge.

Top module: `divclk_bank`

## Requirements
- R1: Output i follows the source whose index is held in out_sel[i*SEL_W +: SEL_W]; an index of NUM_SRC or more selects source 0.
- R2: With code d in out_div[i*DIV_W +: DIV_W], a running output repeats every d+1 ticks of its source. It is high for max(1, floor((d+1)/2)) ticks and low for the rest, so odd divides are high one tick less than low. It changes only on a bank clock edge where its source ticks.
- R3: After the shared clear of a source goes low, the two following source ticks keep unmasked outputs low. The output first goes high on the third tick.
- R4: While the shared clear of its source is high, an unmasked output is low from the next bank clock edge on, without waiting for a tick.
- R5: Both edges of a source's shared enable take effect two source ticks late. While it is effectively low, unmasked outputs hold their level and count. On return they continue from where they stopped.
- R6: An output with its clear mask bit set ignores the shared clear.
- R7: An output with its enable mask bit set ignores the shared enable and keeps running.
- R8: All unmasked outputs on one source rise on the same bank clock edge when they leave clear.
- R9: A masked output keeps its phase across a clear pulse that restarts its unmasked neighbours.
- R10: The select and divide fields of an output change only while that output is held in clear; an output changed that way stays low until released.
- R11: While rst_n is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | One strobe per source clock edge |
| grp_en | input | NUM_SRC | Shared enable per source |
| grp_clr | input | NUM_SRC | Shared clear per source |
| out_sel | input | NUM_OUT*SEL_W | Source index per output |
| out_div | input | NUM_OUT*DIV_W | Divide code per output (divide = code+1) |
| en_mask | input | NUM_OUT | Per-output enable mask, 1 = ignore enable |
| clr_mask | input | NUM_OUT | Per-output clear mask, 1 = ignore clear |
| clk_out | output | NUM_OUT | Divided clock outputs |

## Verification
The assertions take for granted that an output's select and divide fields move only in a cycle after that output was held in clear. They also assume the selected source's clear and mask are the only path that forces an output low outside a tick. The stimulus raises every shared clear one cycle before it rewrites any field and keeps those fields fixed through the mask and enable phases. Tick spacing differs per source, so the ticks of different sources never line up in a way the checks depend on.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

   // Control seen by the outputs of one source after synchronization.
   typedef struct packed {
      logic tick;
      logic run_en;
      logic clr_hold;
   } src_ctl_t;

   // Number of high ticks in one output period for divide code.
   function automatic int high_ticks(input int code);
      if (code == 0) return 1;
      return (code + 1) / 2;
   endfunction

endpackage

// File: rtl/divclk_src_sync.sv
module divclk_src_sync
   import divclk_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     grp_en,
   input  logic     grp_clr,
   output src_ctl_t ctl
);

   if (STAGES < 2) begin : g_bad_stages
      $error("divclk_src_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] clr_pipe;
   logic [STAGES-1:0] en_pipe;

   // Clear asserts at once, releases only through the tick pipeline.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_pipe <= '1;
      end else if (grp_clr) begin
         clr_pipe <= '1;
      end else if (tick) begin
         clr_pipe <= {clr_pipe[STAGES-2:0], 1'b0};
      end
   end

   // Both enable edges travel through the tick pipeline.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_pipe <= '0;
      end else if (tick) begin
         en_pipe <= {en_pipe[STAGES-2:0], grp_en};
      end
   end

   always_comb begin
      ctl.tick     = tick;
      ctl.run_en   = en_pipe[STAGES-1];
      ctl.clr_hold = grp_clr | clr_pipe[STAGES-1];
   end

endmodule

// File: rtl/divclk_src_mux.sv
module divclk_src_mux
   import divclk_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 2
) (
   input  src_ctl_t [NUM_SRC-1:0] ctl_all,
   input  logic     [SEL_W-1:0]   sel,
   output src_ctl_t               ctl
);

   localparam int SEL_SPAN = 1 << SEL_W;

   if (SEL_SPAN < NUM_SRC) begin : g_bad_sel
      $error("divclk_src_mux: SEL_W too narrow for NUM_SRC");
   end

   if (SEL_SPAN == NUM_SRC) begin : g_full
      // Every select code names a real source.
      assign ctl = ctl_all[sel];
   end else begin : g_clamp
      // Codes past the last source fall back to source 0.
      logic in_range;
      assign in_range = (sel < SEL_W'(NUM_SRC));
      assign ctl      = in_range ? ctl_all[sel] : ctl_all[0];
   end

endmodule

// File: rtl/divclk_out_div.sv
module divclk_out_div
   import divclk_pkg::*;
#(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic             clr_act,
   input  logic [DIV_W-1:0] div,
   output logic             clk_o
);

   if (DIV_W < 1) begin : g_bad_div
      $error("divclk_out_div: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] phase;
   logic [DIV_W-1:0] phase_nxt;
   logic             level_nxt;

   always_comb begin
      phase_nxt = (phase >= div) ? '0 : phase + 1'b1;
      level_nxt = (int'(phase_nxt) < high_ticks(int'(div)));
   end

   // Clear parks the count at its last phase so the next tick starts high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '1;
         clk_o <= 1'b0;
      end else if (clr_act) begin
         phase <= div;
         clk_o <= 1'b0;
      end else if (tick && run_en) begin
         phase <= phase_nxt;
         clk_o <= level_nxt;
      end
   end

endmodule

// File: rtl/divclk_bank.sv
module divclk_bank
   import divclk_pkg::*;
#(
   parameter int NUM_OUT     = 24,
   parameter int NUM_SRC     = 4,
   parameter int DIV_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       src_tick,
   input  logic [NUM_SRC-1:0]       grp_en,
   input  logic [NUM_SRC-1:0]       grp_clr,
   input  logic [NUM_OUT*SEL_W-1:0] out_sel,
   input  logic [NUM_OUT*DIV_W-1:0] out_div,
   input  logic [NUM_OUT-1:0]       en_mask,
   input  logic [NUM_OUT-1:0]       clr_mask,
   output logic [NUM_OUT-1:0]       clk_out
);

   if (NUM_OUT < 1) begin : g_bad_out
      $error("divclk_bank: NUM_OUT must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("divclk_bank: NUM_SRC must be at least 1");
   end

   src_ctl_t [NUM_SRC-1:0] src_ctl;
   logic     [NUM_OUT-1:0] tick_sel;
   logic     [NUM_OUT-1:0] en_act;
   logic     [NUM_OUT-1:0] clr_act;

   // One synchronizer pair per source, shared by all its outputs.
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      divclk_src_sync #(
         .STAGES (SYNC_STAGES)
      ) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (src_tick[s]),
         .grp_en  (grp_en[s]),
         .grp_clr (grp_clr[s]),
         .ctl     (src_ctl[s])
      );
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      src_ctl_t sel_ctl;

      divclk_src_mux #(
         .NUM_SRC (NUM_SRC),
         .SEL_W   (SEL_W)
      ) i_mux (
         .ctl_all (src_ctl),
         .sel     (out_sel[i*SEL_W +: SEL_W]),
         .ctl     (sel_ctl)
      );

      assign tick_sel[i] = sel_ctl.tick;
      assign en_act[i]   = sel_ctl.run_en | en_mask[i];
      assign clr_act[i]  = sel_ctl.clr_hold & ~clr_mask[i];

      divclk_out_div #(
         .DIV_W (DIV_W)
      ) i_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick_sel[i]),
         .run_en  (en_act[i]),
         .clr_act (clr_act[i]),
         .div     (out_div[i*DIV_W +: DIV_W]),
         .clk_o   (clk_out[i])
      );
   end

endmodule

// File: rtl/divclk_bank_chk.sv
module divclk_bank_chk #(
   parameter int NUM_OUT = 24,
   parameter int NUM_SRC = 4,
   parameter int DIV_W   = 3,
   parameter int SEL_W   = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_SRC-1:0]       grp_clr,
   input logic [NUM_OUT*SEL_W-1:0] out_sel,
   input logic [NUM_OUT*DIV_W-1:0] out_div,
   input logic [NUM_OUT-1:0]       clr_mask,
   input logic [NUM_OUT-1:0]       clk_out,
   input logic [NUM_OUT-1:0]       tick_sel,
   input logic [NUM_OUT-1:0]       en_act,
   input logic [NUM_OUT-1:0]       clr_act
);

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
      logic [SEL_W-1:0] sel_i;
      logic             clr_in_i;

      assign sel_i    = out_sel[i*SEL_W +: SEL_W];
      assign clr_in_i = (sel_i < SEL_W'(NUM_SRC)) ? grp_clr[sel_i] : grp_clr[0];

      // R4
      clear_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_in_i && !clr_mask[i]) |=> !clk_out[i]);

      // R2
      tick_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick_sel[i] && !clr_act[i]) |=> $stable(clk_out[i]));

      // R5
      enable_low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_act[i] && !clr_act[i]) |=> $stable(clk_out[i]));

      // R10
      sel_change_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $changed(out_sel[i*SEL_W +: SEL_W]) |-> $past(clr_act[i]));

      // R10
      div_change_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $changed(out_div[i*DIV_W +: DIV_W]) |-> $past(clr_act[i]));
   end

endmodule

bind divclk_bank divclk_bank_chk #(
   .NUM_OUT (NUM_OUT),
   .NUM_SRC (NUM_SRC),
   .DIV_W   (DIV_W),
   .SEL_W   (SEL_W)
) i_divclk_bank_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .grp_clr  (grp_clr),
   .out_sel  (out_sel),
   .out_div  (out_div),
   .clr_mask (clr_mask),
   .clk_out  (clk_out),
   .tick_sel (tick_sel),
   .en_act   (en_act),
   .clr_act  (clr_act)
);

// File: tb/test_divclk_bank.sv
`timescale 1ns/1ps
module test_divclk_bank;

   localparam int NO = 8;
   localparam int NS = 3;
   localparam int DW = 3;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_tick = '0;
   logic [NS-1:0] grp_en = '1;
   logic [NS-1:0] grp_clr = '1;
   logic [NO*SW-1:0] out_sel = '0;
   logic [NO*DW-1:0] out_div = '0;
   logic [NO-1:0] en_mask = '0;
   logic [NO-1:0] clr_mask = '0;
   logic [NO-1:0] clk_out;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   // Bench model state
   int clrcnt [NS];
   bit en_d1 [NS];
   bit en_d2 [NS];
   bit rel_edge [NS];
   int ph [NO];
   bit exp_o [NO];
   string tag [NO];

   always #10 clk = ~clk;

   divclk_bank #(
      .NUM_OUT (NO),
      .NUM_SRC (NS),
      .DIV_W   (DW)
   ) i_divclk_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .grp_en   (grp_en),
      .grp_clr  (grp_clr),
      .out_sel  (out_sel),
      .out_div  (out_div),
      .en_mask  (en_mask),
      .clr_mask (clr_mask),
      .clk_out  (clk_out)
   );

   task automatic check(input string req, input logic act, input logic expv, input int idx);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s out%0d cycle %0d: actual=%0b expected=%0b", req, idx, cyc, act, expv);
      end
   endtask

   function automatic int sel_of(input int i);
      int v = int'(out_sel[i*SW +: SW]);
      return (v < NS) ? v : 0;
   endfunction

   function automatic int div_of(input int i);
      return int'(out_div[i*DW +: DW]);
   endfunction

   // Predict the next edge from current inputs, then compare at the negedge.
   task automatic step();
      for (int s = 0; s < NS; s++) src_tick[s] = ((cyc % (s + 1)) == 0);
      for (int i = 0; i < NO; i++) begin
         int s = sel_of(i);
         int n = div_of(i) + 1;
         int h = (div_of(i) == 0) ? 1 : n / 2;
         if (!clr_mask[i] && (grp_clr[s] || clrcnt[s] < 2)) begin
            ph[i] = n - 1;
            exp_o[i] = 1'b0;
            tag[i] = grp_clr[s] ? "R4" : "R3";
         end else if (src_tick[s] && (en_mask[i] || en_d2[s])) begin
            ph[i] = (ph[i] >= n - 1) ? 0 : ph[i] + 1;
            exp_o[i] = (ph[i] < h);
            tag[i] = clr_mask[i] ? "R9" : (en_mask[i] ? "R7" : "R2");
         end else begin
            tag[i] = src_tick[s] ? "R5" : "R2";
         end
      end
      for (int s = 0; s < NS; s++) begin
         rel_edge[s] = src_tick[s] && !grp_clr[s] && (clrcnt[s] == 2);
         if (grp_clr[s]) clrcnt[s] = 0;
         else if (src_tick[s] && clrcnt[s] < 1000) clrcnt[s]++;
         if (src_tick[s]) begin
            en_d2[s] = en_d1[s];
            en_d1[s] = grp_en[s];
         end
      end
      @(negedge clk);
      cyc++;
      for (int i = 0; i < NO; i++) check(tag[i], clk_out[i], exp_o[i], i);
      // R8: unmasked outputs on a releasing source rise together
      for (int s = 0; s < NS; s++) begin
         if (rel_edge[s]) begin
            for (int i = 0; i < NO; i++)
               if (sel_of(i) == s && !clr_mask[i]) check("R8", clk_out[i], 1'b1, i);
         end
      end
   endtask

   task automatic run(input int k);
      for (int c = 0; c < k; c++) step();
   endtask

   initial begin
      #(20 * 60000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) begin
         clrcnt[s] = 0; en_d1[s] = 0; en_d2[s] = 0; rel_edge[s] = 0;
      end
      for (int i = 0; i < NO; i++) begin
         ph[i] = 0; exp_o[i] = 0; tag[i] = "R2";
      end
      // R11: reset holds all outputs low
      repeat (3) @(negedge clk);
      for (int i = 0; i < NO; i++) check("R11", clk_out[i], 1'b0, i);
      rst_n = 1'b1;

      // R1 R2 R3 R8: sweep of sources and every divide code
      for (int r = 0; r < 3; r++) begin
         grp_clr = '1;
         step();
         for (int i = 0; i < NO; i++) begin
            out_sel[i*SW +: SW] = SW'((i + r) % NS);
            out_div[i*DW +: DW] = DW'((i * 3 + r) % 8);
         end
         run(2);
         // R10: reconfigured output stays low while cleared
         for (int i = 0; i < NO; i++) check("R10", clk_out[i], 1'b0, i);
         grp_clr = '0;
         run(60);
      end

      // R6 R9: clear pulse with odd outputs masked
      clr_mask = 8'b1010_1010;
      run(5);
      grp_clr = '1;
      run(4);
      grp_clr = '0;
      run(40);

      // R5 R7: enable drop with even outputs masked
      clr_mask = '0;
      en_mask = 8'b0101_0101;
      run(3);
      grp_en = '0;
      run(14);
      grp_en = '1;
      run(40);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule